// File: doc/BRIEF.md
# Free-Running Timer with Paired Output Compare

This block is a free-running up-counter that runs off a power-of-two division of the system clock. Four compare channels watch it. Each channel raises a sticky match flag when the counter reaches that channel's value. Channels are grouped two by two, and each group drives one output pin. In paired mode the even channel of a group sets the pin and the odd channel clears it, which yields a PWM-like waveform. In unpaired mode every match toggles the group's pin. When the counter wraps it raises an overflow flag. As an option, the counter can restart from zero after it reaches the value of channel 0, which sets the waveform period. Compare writes are double-buffered, so a new value never cuts a waveform period short.

Control is a small register port: write enable, address and data, with a combinational read. A two-state controller (ST_IDLE, ST_RUN) gates counting. The START transition goes from ST_IDLE to ST_RUN when the run bit is written as 1. The HALT transition goes from ST_RUN to ST_IDLE when the run bit is written as 0. Software sets up the compare values while the timer is stopped, then starts the timer with a soft clear so that the counter begins from a known phase. The interrupt line services the flags.

Address map: 0 control, 1 flags (write 1 to clear), 2 interrupt enables, 3 counter (read-only), 4+i compare channel i.

The control register fields are:
- bit 0: run (reads back the controller state)
- bits 3:1: prescaler select
- bit 4: clear-on-match with channel 0
- bit 5: paired mode
- bit 6: soft clear (write-only action, reads 0)

Flag and enable bits: bit 0 is overflow, and bit 1+i is the match flag of channel i.

Top module: `frt_oc_timer`

## Requirements
- R1: After reset the timer is in ST_IDLE. Control, flags, enables, counter and pins read 0, and every compare value reads all ones.
- R2: After a write of run=1 with soft clear at prescaler select s (control bits 3:1), the counter reads floor(N / 2^s) mod 2^CNT_W N system clock cycles later.
- R3: When the counter wraps from all ones to zero, flag bit 0 is set.
- R4: While the timer is in ST_IDLE (run bit 0), the counter holds its value. Control bit 0 reads the current state.
- R5: Writing 1 to control bit 6 zeroes the counter, the prescaler phase and all output pins. The bit always reads back 0.
- R6: Flag bit 1+i is set on the tick on which the counter takes the value of compare channel i.
- R7: With control bit 4 set, the tick after the counter equals compare channel 0 loads zero, so the period is value+1 ticks. This clear does not set the overflow flag, even when the value is all ones.
- R8: With control bit 5 set, a match on channel 2k drives pin k high and a match on channel 2k+1 drives it low. When both match on the same tick, high wins.
- R9: With control bit 5 clear, each matching channel of pair k toggles pin k.
- R10: A write to address 4+i goes to a buffer. The active value, which is the value read back and compared, takes the buffer value on the next wrap, clear-on-match or soft clear. While the timer is in ST_IDLE it takes it on the following cycle.
- R11: Writing 1 to a bit at address 1 clears that flag only. Writing 0 has no effect.
- R12: irq is high exactly when some flag is set whose enable bit at address 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for addr |
| irq | output | 1 | Interrupt request |
| oc_pin | output | N_CH/2 | One compare output per channel pair |

## Verification
The bench builds the timer with an 8-bit counter and the default four channels. This makes the overflow reachable in 256 ticks, so every counter value can be swept cycle by cycle. At that width every prescaler setting can be checked against floor division, and every match flag can be checked against the counter on each cycle of a full count. Clear-on-match is checked for a short period and at the all-ones value, the one case where it competes with overflow. Both pin modes are compared with an arithmetic model of the set, clear and toggle events over several periods.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_RUN} frt_state_e;

    localparam int A_CTRL = 0;
    localparam int A_FLAG = 1;
    localparam int A_IEN  = 2;
    localparam int A_CNT  = 3;
    localparam int A_CMP  = 4;

    localparam int B_RUN  = 0;
    localparam int B_SEL  = 1;
    localparam int SEL_W  = 3;
    localparam int B_CLRM = 4;
    localparam int B_PAIR = 5;
    localparam int B_SCLR = 6;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] mask;

    // low 'sel' bits of the phase must all be ones for a tick
    always_comb begin
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(sel));
        end
    end

    assign tick = run && ((phase & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (run) begin
            phase <= phase + 1'b1;
        end
    end

    // R2: with a divider above 1, ticks are never back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel != '0 && tick) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/frt_core.sv
module frt_core
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic             soft_clr,
    input  logic             tick,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp0,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             adv,
    output logic             ovf_evt,
    output logic             wrap_evt
);
    frt_state_e state_q, state_d;
    logic       hit0;
    logic       at_max;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_wr && run_val)  state_d = ST_RUN;
            ST_RUN:  if (run_wr && !run_val) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller and next count
    always_comb begin
        running  = (state_q == ST_RUN);
        adv      = running && tick;
        hit0     = clr_on_match && (cnt == cmp0);
        at_max   = (cnt == {CNT_W{1'b1}});
        nxt      = hit0 ? '0 : cnt + 1'b1;
        ovf_evt  = adv && !hit0 && at_max;
        wrap_evt = adv && (hit0 || at_max);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (soft_clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= nxt;
        end
    end

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !soft_clr) |=> $stable(cnt));

    assert_clear_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && clr_on_match && cnt == cmp0) |=> cnt == '0);
endmodule

// File: rtl/frt_cmp_bank.sv
module frt_cmp_bank #(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int N_PAIR = N_CH / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            buf_we,
    input  logic [CNT_W-1:0]           wdata,
    input  logic                       load,
    input  logic                       adv,
    input  logic [CNT_W-1:0]           nxt,
    input  logic                       pair_mode,
    input  logic                       soft_clr,
    output logic [N_CH-1:0]            match,
    output logic [N_CH-1:0][CNT_W-1:0] active,
    output logic [N_PAIR-1:0]          pin
);
    logic [N_CH-1:0][CNT_W-1:0] shadow;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[i] <= '1;
                active[i] <= '1;
            end else begin
                if (buf_we[i]) shadow[i] <= wdata;
                if (load)      active[i] <= shadow[i];
            end
        end

        assign match[i] = adv && (nxt == active[i]);

        // R10: the active value moves only on a load
        assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(active[i]));
    end

    for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin[k] <= 1'b0;
            end else if (soft_clr) begin
                pin[k] <= 1'b0;
            end else if (pair_mode) begin
                if (match[2*k])        pin[k] <= 1'b1;
                else if (match[2*k+1]) pin[k] <= 1'b0;
            end else begin
                pin[k] <= pin[k] ^ match[2*k] ^ match[2*k+1];
            end
        end

        assert_pair_set_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_mode && !match[2*k] && !soft_clr) |=> !$rose(pin[k]));

        assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!pair_mode && !soft_clr && (match[2*k] ^ match[2*k+1])) |=> pin[k] != $past(pin[k]));
    end
endmodule

// File: rtl/frt_oc_timer.sv
module frt_oc_timer
    import frt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CNT_W-1:0]      wdata,
    output logic [CNT_W-1:0]      rdata,
    output logic                  irq,
    output logic [N_CH/2-1:0]     oc_pin
);
    localparam int N_PAIR = N_CH / 2;
    localparam int N_FLAG = N_CH + 1;

    logic [SEL_W-1:0]            sel_q;
    logic                        clrm_q;
    logic                        pair_q;
    logic [N_FLAG-1:0]           flags_q;
    logic [N_FLAG-1:0]           ien_q;
    logic [N_FLAG-1:0]           flag_clr;
    logic                        wr_ctrl;
    logic                        soft_clr;
    logic                        tick;
    logic                        running;
    logic [CNT_W-1:0]            cnt;
    logic [CNT_W-1:0]            nxt;
    logic                        adv;
    logic                        ovf_evt;
    logic                        wrap_evt;
    logic                        load;
    logic [N_CH-1:0]             buf_we;
    logic [N_CH-1:0]             match;
    logic [N_CH-1:0][CNT_W-1:0]  active;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
    assign soft_clr = wr_ctrl && wdata[B_SCLR];
    assign flag_clr = (wr_en && addr == ADDR_W'(A_FLAG)) ? wdata[N_FLAG-1:0] : '0;
    assign load     = !running || soft_clr || wrap_evt;

    for (genvar i = 0; i < N_CH; i++) begin : g_we
        assign buf_we[i] = wr_en && (addr == ADDR_W'(A_CMP + i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            clrm_q  <= 1'b0;
            pair_q  <= 1'b0;
            ien_q   <= '0;
            flags_q <= '0;
        end else begin
            if (wr_ctrl) begin
                sel_q  <= wdata[B_SEL +: SEL_W];
                clrm_q <= wdata[B_CLRM];
                pair_q <= wdata[B_PAIR];
            end
            if (wr_en && addr == ADDR_W'(A_IEN)) ien_q <= wdata[N_FLAG-1:0];
            flags_q <= (flags_q & ~flag_clr) | {match, ovf_evt};
        end
    end

    frt_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .clr  (soft_clr),
        .sel  (sel_q),
        .tick (tick)
    );

    frt_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_wr      (wr_ctrl),
        .run_val     (wdata[B_RUN]),
        .soft_clr    (soft_clr),
        .tick        (tick),
        .clr_on_match(clrm_q),
        .cmp0        (active[0]),
        .running     (running),
        .cnt         (cnt),
        .nxt         (nxt),
        .adv         (adv),
        .ovf_evt     (ovf_evt),
        .wrap_evt    (wrap_evt)
    );

    frt_cmp_bank #(.CNT_W(CNT_W), .N_CH(N_CH), .N_PAIR(N_PAIR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_we   (buf_we),
        .wdata    (wdata),
        .load     (load),
        .adv      (adv),
        .nxt      (nxt),
        .pair_mode(pair_q),
        .soft_clr (soft_clr),
        .match    (match),
        .active   (active),
        .pin      (oc_pin)
    );

    assign irq = |(flags_q & ien_q);

    always_comb begin
        rdata = '0;
        unique case (int'(addr))
            A_CTRL: begin
                rdata[B_RUN]          = running;
                rdata[B_SEL +: SEL_W] = sel_q;
                rdata[B_CLRM]         = clrm_q;
                rdata[B_PAIR]         = pair_q;
            end
            A_FLAG:  rdata[N_FLAG-1:0] = flags_q;
            A_IEN:   rdata[N_FLAG-1:0] = ien_q;
            A_CNT:   rdata = cnt;
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (addr == ADDR_W'(A_CMP + i)) rdata = active[i];
                end
            end
        endcase
    end

    // R3: the overflow flag rises only together with a counter at zero
    assert_ovf_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> cnt == '0);

    // R12: no interrupt without a pending flag
    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags_q != '0);
endmodule

// File: tb/tb_frt_oc_timer.sv
module tb_frt_oc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [1:0] oc_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frt_oc_timer #(.CNT_W(8), .N_CH(4), .ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .oc_pin(oc_pin)
    );

    function automatic logic [7:0] ctrl(input bit run, input int sel, input bit clrm,
                                        input bit pair, input bit sclr);
        return {1'b0, sclr, pair, clrm, sel[2:0], run};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[2:0]; wdata = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = a[2:0];
        #1;
        v = int'(rdata);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int cv[4];
        int p0, p1, c;
        bit found;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 flags", v, 0);
        rd(2, v); check("R1 ien", v, 0);
        rd(3, v); check("R1 cnt", v, 0);
        check("R1 irq", irq, 0);
        check("R1 pins", oc_pin, 0);
        for (int i = 0; i < 4; i++) begin
            rd(4 + i, v); check("R1 cmp", v, 255);
        end
        repeat (10) @(negedge clk);
        rd(3, v); check("R4 idle hold after reset", v, 0);

        // R2 prescaler sweep; R5 soft clear bit reads 0
        for (int s = 0; s < 8; s++) begin
            do_wr(0, ctrl(1, s, 0, 0, 1));
            repeat (300) @(negedge clk);
            rd(3, v); check("R2 prescaled count", v, (300 >> s) & 255);
            rd(0, v); check("R5 ctrl readback", v, ctrl(1, s, 0, 0, 0));
        end

        // R4 stop holds counter
        do_wr(0, ctrl(0, 0, 0, 0, 0));
        rd(0, v); check("R4 run bit", v & 1, 0);
        rd(3, c);
        repeat (50) @(negedge clk);
        rd(3, v); check("R4 hold", v, c);

        // R3 overflow, R11 W1C, R12 irq
        do_wr(1, 8'h1F);
        rd(1, v); check("R11 clear all", v, 0);
        do_wr(0, ctrl(1, 0, 0, 0, 1));
        repeat (255) @(negedge clk);
        rd(3, v); check("R3 count at max", v, 255);
        rd(1, v); check("R3 no flag before wrap", v & 1, 0);
        @(negedge clk);
        rd(3, v); check("R3 count wrapped", v, 0);
        rd(1, v); check("R3 flag set", v & 1, 1);
        check("R12 irq masked", irq, 0);
        do_wr(2, 8'h01);
        check("R12 irq enabled", irq, 1);
        do_wr(1, 8'h00);
        rd(1, v); check("R11 write zero no effect", v, 8'h1F);
        do_wr(1, 8'h01);
        rd(1, v); check("R11 selective clear", v, 8'h1E);
        check("R12 irq after clear", irq, 0);
        do_wr(0, ctrl(0, 0, 0, 0, 0));

        // R6 match flags, R10 idle load
        cv[0] = 40; cv[1] = 100; cv[2] = 7; cv[3] = 200;
        for (int i = 0; i < 4; i++) do_wr(4 + i, cv[i]);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd(4 + i, v); check("R10 idle load", v, cv[i]);
        end
        do_wr(1, 8'h1F);
        do_wr(0, ctrl(1, 0, 0, 0, 1));
        for (int k = 1; k < 256; k++) begin
            int e;
            @(negedge clk);
            e = 0;
            for (int i = 0; i < 4; i++) if (k >= cv[i]) e |= (2 << i);
            rd(1, v); check("R6 match flags", v, e);
            rd(3, v); check("R6 count", v, k);
        end
        do_wr(0, ctrl(0, 0, 0, 0, 0));

        // R7 clear-on-match, R8 paired pins
        cv[0] = 40; cv[1] = 20;
        do_wr(4, 40); do_wr(5, 20);
        @(negedge clk);
        do_wr(1, 8'h1F);
        do_wr(0, ctrl(1, 0, 1, 1, 1));
        p0 = 0; p1 = 0;
        for (int n = 1; n <= 300; n++) begin
            @(negedge clk);
            c = n % 41;
            if (c == cv[0]) p0 = 1; else if (c == cv[1]) p0 = 0;
            if (c == cv[2]) p1 = 1; else if (c == cv[3]) p1 = 0;
            rd(3, v); check("R7 period", v, c);
            check("R8 paired pins", oc_pin, p1 * 2 + p0);
        end
        rd(1, v); check("R7 no overflow", v & 1, 0);

        // R8 both pair channels equal: set wins
        do_wr(0, ctrl(0, 0, 1, 1, 0));
        do_wr(5, 40);
        @(negedge clk);
        do_wr(0, ctrl(1, 0, 1, 1, 1));
        repeat (45) @(negedge clk);
        check("R8 set wins", oc_pin[0], 1);

        // R7 clear-on-match at all ones
        do_wr(0, ctrl(0, 0, 1, 0, 0));
        do_wr(4, 255);
        @(negedge clk);
        do_wr(1, 8'h1F);
        do_wr(0, ctrl(1, 0, 1, 0, 1));
        repeat (256) @(negedge clk);
        rd(3, v); check("R7 cleared at max", v, 0);
        rd(1, v); check("R7 overflow suppressed", v & 1, 0);
        check("R7 ch0 flag", (v >> 1) & 1, 1);

        // R9 unpaired toggles
        do_wr(0, ctrl(0, 0, 1, 0, 0));
        cv[0] = 40; cv[1] = 20; cv[2] = 10; cv[3] = 30;
        for (int i = 0; i < 4; i++) do_wr(4 + i, cv[i]);
        @(negedge clk);
        do_wr(0, ctrl(1, 0, 1, 0, 1));
        p0 = 0; p1 = 0;
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            c = n % 41;
            p0 = p0 ^ int'(c == cv[0]) ^ int'(c == cv[1]);
            p1 = p1 ^ int'(c == cv[2]) ^ int'(c == cv[3]);
            check("R9 toggled pins", oc_pin, p1 * 2 + p0);
        end

        // R5 soft clear zeroes pins and count
        do_wr(0, ctrl(1, 0, 1, 0, 1));
        repeat (15) @(negedge clk);
        rd(3, v); check("R5 pre count", v, 15);
        check("R5 pins before clear", oc_pin, 2);
        do_wr(0, ctrl(1, 0, 1, 0, 1));
        rd(3, v); check("R5 count cleared", v, 0);
        check("R5 pins cleared", oc_pin, 0);

        // R10 double buffering while running
        do_wr(5, 33);
        rd(5, v); check("R10 old value kept", v, 20);
        found = 1'b0;
        rd(3, v);
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            rd(3, v);
            if (v == 0) begin found = 1'b1; break; end
        end
        check("R10 wrap seen", found, 1);
        rd(5, v); check("R10 new value after wrap", v, 33);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule